// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit general register value into a binary floating-point number. A 2-bit type code chooses whether the operand is signed or unsigned, and whether it is 32 or 64 bits wide. A precision select chooses between a double result and a single result. A single result is rounded to a 24-bit significand and then returned in double layout, so its low 29 fraction bits are always zero. Rounding follows a 2-bit mode input. Alongside the value the block reports an increment flag, an inexact flag, a 5-bit result class and an inexact exception pulse. A status write-enable tells the surrounding unit whether those status fields apply.

Operands enter on a valid/ready stream and results leave on a second one. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows up on the output one cycle later. The output register keeps the result and every status output unchanged while `out_valid` is high and `out_ready` is low. While that stall lasts, `in_ready` stays low, so back-pressure travels straight up the stream. When `out_ready` is high, a new beat can be accepted in the same cycle that the held result leaves.

Top module: `ifc_convert`

## Requirements
- R1: The type code sets the operand kind: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. A signed operand gives a result whose sign bit (bit 63) is set exactly when the operand is negative.
- R2: For type codes 0 and 1, only the low 32 bits `in_src[31:0]` are used. Whatever is in `in_src[63:32]` has no effect on any output.
- R3: For a 32-bit operand converted to double (type code 0 or 1 with `in_single` low), the result is exact. `out_stat_we` is 0 and `out_fr`, `out_fi`, `out_xx` and `out_fprf` are all 0. In every other case `out_stat_we` is 1.
- R4: Rounding mode 0 rounds to nearest with ties to even. Mode 1 rounds toward zero. Mode 2 rounds toward +infinity. Mode 3 rounds toward -infinity.
- R5: With `in_single` high, the value is rounded to a 24-bit significand and placed in double layout: exponent bias 1023 and a 52-bit fraction whose low 29 bits are zero.
- R6: When `out_stat_we` is 1, `out_fr` is 1 exactly when rounding incremented the magnitude. `out_fi` is 1 exactly when the result differs from the operand. `out_xx` equals `out_fi`.
- R7: When `out_stat_we` is 1, `out_fprf` holds the class code: 0x02 for +0, 0x04 for a positive normal and 0x08 for a negative normal.
- R8: The most negative signed 64-bit value converts exactly to -2^63, which is 0xC3E0000000000000.
- R9: An operand of zero converts to +0.0 (all 64 bits zero) and is never inexact.
- R10: If rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero. For example, unsigned 64-bit all-ones with mode 0 gives 0x43F0000000000000.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold. A beat accepted on an edge gives `out_valid` high after that edge.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Block can take an operand |
| in_src | input | 64 | Source register value |
| in_itype | input | 2 | Operand type code |
| in_single | input | 1 | 1 = single-precision result in double layout |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer can take the result |
| out_result | output | 64 | Result in double layout |
| out_fr | output | 1 | Magnitude was incremented by rounding |
| out_fi | output | 1 | Result is inexact |
| out_fprf | output | 5 | Result class code |
| out_xx | output | 1 | Inexact exception pulse |
| out_stat_we | output | 1 | Status outputs apply to this result |

## Verification
The two events that can share one cycle are the acceptance of a new operand and the departure of the held result. A second pair can also coincide: a rounding carry that raises the exponent, together with the increment and inexact flags.

The sweep keeps `in_valid` asserted whenever `in_ready` allows it. It drops `out_ready` on a fixed cadence, so accept-while-drain cycles and stalls are mixed together, and every delivered result is compared in order against an arithmetic model. A directed case stalls a -2^63 result while an all-ones unsigned operand waits. It then releases the stall and checks the carried 2^64 result and its flags.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  localparam int SRC_W      = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_BIAS   = 1023;
  localparam int CLS_W      = 5;

  typedef enum logic [1:0] {
    IT_S32 = 2'd0,
    IT_U32 = 2'd1,
    IT_S64 = 2'd2,
    IT_U64 = 2'd3
  } itype_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_PZERO = 5'h02;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'h04;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'h08;

  typedef struct packed {
    logic [SRC_W-1:0] result;
    logic             fr;
    logic             fi;
    logic [CLS_W-1:0] fprf;
    logic             xx;
    logic             stat_we;
  } conv_res_t;

endpackage

// File: rtl/ifc_prep.sv
module ifc_prep
  import ifc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [1:0]   itype,
  output logic         sign,
  output logic [W-1:0] mag,
  output logic         is_zero
);
  localparam int HW = W / 2;

  logic [W-1:0] ext_s;
  logic [W-1:0] ext_u;

  assign ext_s = {{HW{src[HW-1]}}, src[HW-1:0]};
  assign ext_u = {{HW{1'b0}}, src[HW-1:0]};

  always_comb begin
    sign = 1'b0;
    mag  = src;
    unique case (itype_e'(itype))
      IT_S32: begin
        sign = src[HW-1];
        mag  = sign ? (~ext_s + 1'b1) : ext_s;
      end
      IT_U32: begin
        mag = ext_u;
      end
      IT_S64: begin
        sign = src[W-1];
        mag  = sign ? (~src + 1'b1) : src;
      end
      default: begin
        mag = src;
      end
    endcase
  end

  assign is_zero = (mag == '0);

endmodule

// File: rtl/ifc_lzc.sv
module ifc_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  norm
);
  logic found;

  always_comb begin
    cnt   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (val[i]) found = 1'b1;
        else        cnt   = cnt + 1'b1;
      end
    end
  end

  assign norm = val << cnt;

endmodule

// File: rtl/ifc_round.sv
module ifc_round
  import ifc_pkg::*;
#(
  parameter int W      = 64,
  parameter int FW     = 52,
  parameter int OUT_FW = 52
) (
  input  logic [W-1:0]      norm,
  input  logic              sign,
  input  logic [1:0]        rmode,
  output logic [OUT_FW-1:0] frac,
  output logic              carry,
  output logic              incr,
  output logic              inexact
);
  localparam int KW = FW + 1;
  localparam int GP = W - 1 - KW;
  localparam int SP = GP - 2;

  logic [KW-1:0] kept;
  logic          g_bit;
  logic          r_bit;
  logic          s_bit;
  logic [KW:0]   sum;

  assign kept    = norm[W-1 -: KW];
  assign g_bit   = norm[GP];
  assign r_bit   = norm[GP-1];
  assign s_bit   = |norm[SP:0];
  assign inexact = g_bit | r_bit | s_bit;

  always_comb begin
    unique case (rmode_e'(rmode))
      RM_NEAR: incr = g_bit & (r_bit | s_bit | kept[0]);
      RM_ZERO: incr = 1'b0;
      RM_POS:  incr = ~sign & inexact;
      default: incr = sign & inexact;
    endcase
  end

  assign sum   = {1'b0, kept} + {{KW{1'b0}}, incr};
  assign carry = sum[KW];
  assign frac  = OUT_FW'(sum[FW-1:0]) << (OUT_FW - FW);

endmodule

// File: rtl/ifc_convert.sv
module ifc_convert
  import ifc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_src,
  input  logic [1:0]  in_itype,
  input  logic        in_single,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_result,
  output logic        out_fr,
  output logic        out_fi,
  output logic [4:0]  out_fprf,
  output logic        out_xx,
  output logic        out_stat_we
);
  localparam int CW   = $clog2(SRC_W + 1);
  localparam int NFMT = 2;

  logic             sign;
  logic [SRC_W-1:0] mag;
  logic             is_zero;
  logic [CW-1:0]    lz;
  logic [SRC_W-1:0] norm;

  logic [DBL_FRAC_W-1:0] frac_f  [NFMT];
  logic                  carry_f [NFMT];
  logic                  incr_f  [NFMT];
  logic                  inex_f  [NFMT];

  logic [DBL_FRAC_W-1:0] frac;
  logic                  carry;
  logic                  incr;
  logic                  inexact;
  logic [DBL_EXP_W-1:0]  exp_b;
  logic                  stat_we;
  conv_res_t             nxt;
  conv_res_t             held;
  logic                  held_v;

  ifc_prep #(.W(SRC_W)) u_prep (
    .src     (in_src),
    .itype   (in_itype),
    .sign    (sign),
    .mag     (mag),
    .is_zero (is_zero)
  );

  ifc_lzc #(.W(SRC_W), .CW(CW)) u_lzc (
    .val  (mag),
    .cnt  (lz),
    .norm (norm)
  );

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int FW = (f == 0) ? DBL_FRAC_W : SGL_FRAC_W;
    ifc_round #(.W(SRC_W), .FW(FW), .OUT_FW(DBL_FRAC_W)) u_round (
      .norm    (norm),
      .sign    (sign),
      .rmode   (in_rmode),
      .frac    (frac_f[f]),
      .carry   (carry_f[f]),
      .incr    (incr_f[f]),
      .inexact (inex_f[f])
    );
  end

  assign frac    = in_single ? frac_f[1]  : frac_f[0];
  assign carry   = in_single ? carry_f[1] : carry_f[0];
  assign incr    = in_single ? incr_f[1]  : incr_f[0];
  assign inexact = in_single ? inex_f[1]  : inex_f[0];

  assign exp_b   = DBL_EXP_W'(DBL_BIAS + SRC_W - 1) - DBL_EXP_W'(lz)
                 + DBL_EXP_W'(carry);
  assign stat_we = in_itype[1] | in_single;

  always_comb begin
    nxt         = '0;
    nxt.stat_we = stat_we;
    if (!is_zero) begin
      nxt.result = {sign, exp_b, frac};
    end
    if (stat_we) begin
      nxt.fr   = ~is_zero & incr;
      nxt.fi   = ~is_zero & inexact;
      nxt.xx   = ~is_zero & inexact;
      nxt.fprf = is_zero ? CLS_PZERO : (sign ? CLS_NNORM : CLS_PNORM);
    end
  end

  assign in_ready = ~held_v | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held   <= '0;
    end else if (in_ready) begin
      held_v <= in_valid;
      if (in_valid) held <= nxt;
    end
  end

  assign out_valid   = held_v;
  assign out_result  = held.result;
  assign out_fr      = held.fr;
  assign out_fi      = held.fi;
  assign out_fprf    = held.fprf;
  assign out_xx      = held.xx;
  assign out_stat_we = held.stat_we;

endmodule

// File: rtl/ifc_convert_chk.sv
module ifc_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_fr,
  input logic        out_fi,
  input logic [4:0]  out_fprf,
  input logic        out_xx,
  input logic        out_stat_we
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_fprf) && $stable(out_fi));

  // R11
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R3
  quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_stat_we |-> !out_fr && !out_fi && !out_xx
                                  && out_fprf == 5'h00);

  // R6
  incr_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fr |-> out_fi && out_xx);

  // R7
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat_we |-> $countones(out_fprf) == 1);

  // R9
  zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat_we && out_result == 64'd0 |-> out_fprf == 5'h02
                                                      && !out_fi);

  // R1
  sign_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat_we && out_result[63] |-> out_fprf == 5'h08);

endmodule

bind ifc_convert ifc_convert_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_fr      (out_fr),
  .out_fi      (out_fi),
  .out_fprf    (out_fprf),
  .out_xx      (out_xx),
  .out_stat_we (out_stat_we)
);

// File: tb/ifc_convert_tb.sv
module ifc_convert_tb;
  localparam int NPAT  = 40;
  localparam int NITEM = NPAT * 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [1:0]  in_itype = '0;
  logic        in_single = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_fr, out_fi, out_xx, out_stat_we;
  logic [4:0]  out_fprf;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ifc_convert u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_src (in_src), .in_itype (in_itype), .in_single (in_single),
    .in_rmode (in_rmode), .out_valid (out_valid), .out_ready (out_ready),
    .out_result (out_result), .out_fr (out_fr), .out_fi (out_fi),
    .out_fprf (out_fprf), .out_xx (out_xx), .out_stat_we (out_stat_we)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    logic [63:0] x;
    case (i)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h8000_0000_0000_0000;
      4:  return 64'h7FFF_FFFF_FFFF_FFFF;
      5:  return 64'h0000_0000_8000_0000;
      6:  return 64'h0000_0000_7FFF_FFFF;
      7:  return 64'h0000_0000_FFFF_FFFF;
      8:  return 64'h0020_0000_0000_0001;
      9:  return 64'h0020_0000_0000_0003;
      10: return 64'h0000_0000_0100_0001;
      11: return 64'h0000_0000_0100_0003;
      12: return 64'hDEAD_BEEF_0000_0005; // R2 upper garbage
      13: return 64'h1234_5678_FF80_0001; // R2 upper garbage
      14: return 64'hFFFF_FFFF_0000_0000; // R2 low half zero
      15: return 64'h0000_0000_0000_0003;
      default: begin
        x = 64'(i) * 64'h9E37_79B9_7F4A_7C15;
        x = x ^ (x >> (i % 29));
        return x >> (i % 48);
      end
    endcase
  endfunction

  // Arithmetic reference model, from the requirements.
  task automatic model(input logic [63:0] src, input logic [1:0] it,
                       input logic sgl, input logic [1:0] rm,
                       output logic [63:0] res, output logic [3:0] flg,
                       output logic [4:0] cls, output string tag);
    logic [63:0] v, mag, kept, rem, half;
    logic        sign, up, we;
    int          p, m, sh, e;
    v    = it[1] ? src : (it[0] ? {32'd0, src[31:0]}
                                : {{32{src[31]}}, src[31:0]});
    sign = (it == 2'd0 || it == 2'd2) && v[63];
    mag  = sign ? (64'd0 - v) : v;
    we   = it[1] | sgl;
    m    = sgl ? 23 : 52;
    up   = 1'b0;
    rem  = 0;
    tag  = "R1";
    if (mag == 0) begin
      res = 0; cls = 5'h02; tag = "R9";
    end else begin
      p = 0;
      for (int k = 0; k < 64; k++) if (mag[k]) p = k;
      if (p <= m) begin
        kept = mag << (m - p);
      end else begin
        sh   = p - m;
        kept = mag >> sh;
        rem  = mag & ((64'd1 << sh) - 1);
        half = 64'd1 << (sh - 1);
        case (rm)
          2'd0: up = (rem > half) || (rem == half && kept[0]);
          2'd1: up = 1'b0;
          2'd2: up = !sign && rem != 0;
          default: up = sign && rem != 0;
        endcase
      end
      kept = kept + 64'(up);
      e    = p;
      if (kept == (64'd1 << (m + 1))) begin
        kept = kept >> 1; e = e + 1; tag = "R10";
      end else if (rem != 0) tag = "R4";
      else if (sgl) tag = "R5";
      res = {sign, 11'(e + 1023), 52'((kept & ((64'd1 << m) - 1)) << (52 - m))};
      cls = sign ? 5'h08 : 5'h04;
    end
    if (!it[1] && src[63:32] != 0) tag = "R2";
    if (!we) begin
      tag = (mag == 0) ? tag : "R3";
      flg = 4'b0000; cls = 5'h00;
    end else begin
      flg = {up, rem != 0, rem != 0, 1'b1};
    end
  endtask

  task automatic compare_item(input int n);
    logic [63:0] res;
    logic [3:0]  flg;
    logic [4:0]  cls;
    string       tag;
    int          c;
    c = n % 32;
    model(pat(n / 32), c[1:0], c[2], c[4:3], res, flg, cls, tag);
    check(tag, "result", out_result, res);
    check("R6", "fr/fi/xx/we", 64'({out_fr, out_fi, out_xx, out_stat_we}),
          64'(flg));
    check("R7", "class", 64'(out_fprf), 64'(cls));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int sent, got, cyc, c;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R12
    check("R12", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R12", "in_ready after reset", 64'(in_ready), 64'd1);

    sent = 0; got = 0; cyc = 0;
    while (got < NITEM) begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5) != 3;
      #1;
      if (out_valid && out_ready) begin
        compare_item(got);
        got++;
      end
      if (in_ready && sent < NITEM) begin
        c         = sent % 32;
        in_src    = pat(sent / 32);
        in_itype  = c[1:0];
        in_single = c[2];
        in_rmode  = c[4:3];
        in_valid  = 1'b1;
        sent++;
      end else begin
        in_valid = 1'b0;
      end
    end

    // Directed stall: -2^63 held while an all-ones unsigned operand waits.
    @(negedge clk);
    out_ready = 1'b0;
    in_src = 64'h8000_0000_0000_0000; in_itype = 2'd2;
    in_single = 1'b0; in_rmode = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    in_src = 64'hFFFF_FFFF_FFFF_FFFF; in_itype = 2'd3;
    #1;
    check("R8", "min signed 64", out_result, 64'hC3E0_0000_0000_0000);
    check("R11", "in_ready during stall", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check("R11", "held result", out_result, 64'hC3E0_0000_0000_0000);
      check("R11", "held valid", 64'(out_valid), 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R10", "carry result", out_result, 64'h43F0_0000_0000_0000);
    check("R10", "carry fr/fi", 64'({out_fr, out_fi}), 64'd3);
    @(negedge clk);
    #1;
    check("R11", "drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule